// File: doc/BRIEF.md
# Virtual Calibration Window Redirector

This block sits on a request path in front of an overlay memory and owns a virtual address window of 32 KB that has no storage behind it. Every request is compared against the window. A request outside the window goes straight through to the downstream port in the same cycle, with nothing changed.

A request inside the window depends on a redirect register that software writes. When redirection is on, the block keeps the address bits below the target size and replaces the upper address bits with the programmed target base. It then forwards the access to the physical overlay target. When redirection is off, nothing is forwarded and the block answers the request itself one cycle later:
- a write is acknowledged without error and thrown away;
- a read ends with a bus error and all-zero data.

Responses from the downstream target pass back unchanged. This includes error responses such as ECC reports that partial writes can cause in the overlay RAM.

Top module: `calwin_redirect`

## Requirements
- R1: After reset, redirection is disabled and no response is pending, so a read to the window returns a bus error.
- R2: A request whose address lies outside the window appears on the downstream port in the same cycle with identical valid, write, address, write data and byte strobes.
- R3: An address is in the window exactly when its bits above bit 14 equal those of WIN_BASE. The addresses WIN_BASE-8 and WIN_BASE+0x8000 are outside the window.
- R4: With redirection enabled, a window request is forwarded in the same cycle. Its write, write data and strobes are unchanged, and its address is the target base OR'ed with the offset (address bits 14:0) reduced to the target size.
- R5: The offset wraps on the target size of 2^TGT_AW bytes (8 KB by default), so offsets 0x2008 and 0x0008 map to the same target address.
- R6: With redirection disabled, a window write is not forwarded (dn_valid stays 0). One cycle later, rsp_valid=1 and rsp_err=0.
- R7: With redirection disabled, a window read is not forwarded. One cycle later, rsp_valid=1, rsp_err=1 and rsp_rdata is zero, whatever the downstream data bus carries.
- R8: Bits 14:0 of a value written to the target base are ignored.
- R9: When no local response is issued, dn_rvalid, dn_rdata and dn_err appear unchanged on rsp_valid, rsp_rdata and rsp_err in the same cycle.
- R10: A redirect register write (cfg_we=1) takes effect from the cycle after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Redirect register write strobe |
| cfg_en_in | input | 1 | Redirect enable value to write |
| cfg_base_in | input | ADDR_W | Target base value to write |
| req_valid | input | 1 | Upstream request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Upstream byte address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte strobes |
| dn_valid | output | 1 | Downstream request valid |
| dn_write | output | 1 | Downstream write |
| dn_addr | output | ADDR_W | Downstream (translated) address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_be | output | DATA_W/8 | Downstream byte strobes |
| dn_rvalid | input | 1 | Downstream response valid |
| dn_rdata | input | DATA_W | Downstream read data |
| dn_err | input | 1 | Downstream error (e.g. ECC) |
| rsp_valid | output | 1 | Upstream response valid |
| rsp_rdata | output | DATA_W | Upstream read data |
| rsp_err | output | 1 | Upstream bus error |

## Verification
The redirect path is driven with several kinds of address:
- addresses just below and just above the window, which separate the window compare from a mask that is too wide or too narrow;
- offsets inside the target size;
- offsets past the target size, which show whether the wrap is applied;
- the last offset in the window.

The target base is written with its low bits set, so a translation that leaks those bits shows up. Reads and writes are sent both with and without redirection, which separates the error read from the silent write drop. The read is sent while the downstream data bus carries a non-zero pattern, to show that the block forces the data to zero. A request issued in the same cycle as the register write shows the one-cycle setup delay.

// File: rtl/calwin_redirect.sv
module calwin_redirect #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int WIN_AW = 15,
  parameter int TGT_AW = 13,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h9F00_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_en_in,
  input  logic [ADDR_W-1:0]   cfg_base_in,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                dn_valid,
  output logic                dn_write,
  output logic [ADDR_W-1:0]   dn_addr,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_be,
  input  logic                dn_rvalid,
  input  logic [DATA_W-1:0]   dn_rdata,
  input  logic                dn_err,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err
);
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((64'd1 << WIN_AW) - 1);
  localparam logic [ADDR_W-1:0] TGT_MASK = ADDR_W'((64'd1 << TGT_AW) - 1);

  logic              en_q;
  logic [ADDR_W-1:0] base_q;
  logic              loc_v_q, loc_err_q;
  logic              hit, redir;
  logic [ADDR_W-1:0] xlat_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
    end else if (cfg_we) begin
      en_q   <= cfg_en_in;
      base_q <= cfg_base_in;
    end

  assign hit       = (req_addr & ~WIN_MASK) == (WIN_BASE & ~WIN_MASK);
  assign redir     = hit & en_q;
  assign xlat_addr = (base_q & ~WIN_MASK) | (req_addr & WIN_MASK & TGT_MASK);

  assign dn_valid  = req_valid & (~hit | en_q);
  assign dn_write  = req_write;
  assign dn_addr   = redir ? xlat_addr : req_addr;
  assign dn_wdata  = req_wdata;
  assign dn_be     = req_be;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      loc_v_q   <= 1'b0;
      loc_err_q <= 1'b0;
    end else begin
      loc_v_q   <= req_valid & hit & ~en_q;
      loc_err_q <= ~req_write;
    end

  assign rsp_valid = loc_v_q | dn_rvalid;
  assign rsp_err   = loc_v_q ? loc_err_q : dn_err;
  assign rsp_rdata = loc_v_q ? '0 : dn_rdata;

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit) |-> (dn_valid && dn_addr == req_addr));
  assert_redirect_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && en_q) |->
      (dn_valid && dn_addr[ADDR_W-1:WIN_AW] == base_q[ADDR_W-1:WIN_AW]));
  assert_no_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && !en_q) |-> !dn_valid);
  assert_write_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && !en_q && req_write) |=> (rsp_valid && !rsp_err));
  assert_read_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && !en_q && !req_write) |=> (rsp_valid && rsp_err && rsp_rdata == '0));
  assert_no_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loc_v_q |-> !dn_rvalid);
endmodule

// File: tb/calwin_redirect_tb.sv
module calwin_redirect_tb_top;
  localparam int AW = 32, DW = 64;
  localparam logic [31:0] WB = 32'h9F00_0000;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en_in = 0;
  logic [AW-1:0] cfg_base_in = '0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW/8-1:0] req_be = '0;
  logic dn_valid, dn_write;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic [DW/8-1:0] dn_be;
  logic dn_rvalid = 0, dn_err = 0;
  logic [DW-1:0] dn_rdata = '0;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  calwin_redirect dut_i (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [7:0] be);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    #1;
  endtask

  task automatic finish_req();
    @(posedge clk); @(negedge clk);
    req_valid = 0; #1;
  endtask

  task automatic set_cfg(input logic en, input logic [AW-1:0] b);
    @(negedge clk); cfg_we = 1; cfg_en_in = en; cfg_base_in = b;
    @(posedge clk); @(negedge clk); cfg_we = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 dn_valid", dn_valid, 0);
    drive(0, WB + 32'h40, 0, 8'hFF);
    chk("R1 no forward", dn_valid, 0);
    finish_req();
    chk("R1 rsp_valid", rsp_valid, 1);
    chk("R1 rsp_err", rsp_err, 1);
  endtask

  task automatic t_pass();
    @(negedge clk);
    drive(1, WB - 32'h8, 64'h1122_3344_5566_7788, 8'h0F);
    chk("R2 dn_valid", dn_valid, 1);
    chk("R3 below addr", dn_addr, WB - 32'h8);
    chk("R2 wdata", dn_wdata, 64'h1122_3344_5566_7788);
    chk("R2 be", dn_be, 8'h0F);
    chk("R2 write", dn_write, 1);
    req_addr = WB + 32'h8000; #1;
    chk("R3 above valid", dn_valid, 1);
    chk("R3 above addr", dn_addr, WB + 32'h8000);
    finish_req();
    chk("R2 no local rsp", rsp_valid, 0);
  endtask

  task automatic t_drop_write();
    @(negedge clk);
    drive(1, WB + 32'h100, 64'hDEAD, 8'h03);
    chk("R6 not forwarded", dn_valid, 0);
    finish_req();
    chk("R6 rsp_valid", rsp_valid, 1);
    chk("R6 rsp_err", rsp_err, 0);
    @(negedge clk); #1;
    chk("R6 single rsp", rsp_valid, 0);
  endtask

  task automatic t_err_read();
    @(negedge clk);
    dn_rdata = 64'hA5A5_A5A5_A5A5_A5A5;
    drive(0, WB + 32'h7FF8, 0, 8'hFF);
    chk("R7 not forwarded", dn_valid, 0);
    finish_req();
    chk("R7 rsp_valid", rsp_valid, 1);
    chk("R7 rsp_err", rsp_err, 1);
    chk("R7 rdata zero", rsp_rdata, 0);
    dn_rdata = '0;
  endtask

  task automatic t_enable();
    @(negedge clk);
    cfg_we = 1; cfg_en_in = 1; cfg_base_in = 32'h9FE0_7FFF;
    drive(1, WB + 32'h10, 64'h55, 8'h01);
    chk("R10 still disabled", dn_valid, 0);
    @(posedge clk); @(negedge clk);
    cfg_we = 0; #1;
    chk("R10 now forwarded", dn_valid, 1);
    chk("R8 base low bits ignored", dn_addr, 32'h9FE0_0010);
    chk("R10 late local rsp", rsp_valid, 1);
    chk("R4 wdata", dn_wdata, 64'h55);
    chk("R4 be", dn_be, 8'h01);
    chk("R4 write", dn_write, 1);
    req_write = 0; req_addr = WB + 32'h1FF8; #1;
    chk("R4 top of target", dn_addr, 32'h9FE0_1FF8);
    req_addr = WB + 32'h2008; #1;
    chk("R5 wrap", dn_addr, 32'h9FE0_0008);
    req_addr = WB + 32'h7FF8; #1;
    chk("R5 last offset wrap", dn_addr, 32'h9FE0_1FF8);
    finish_req();
    chk("R4 no local rsp", rsp_valid, 0);
  endtask

  task automatic t_dn_rsp();
    @(negedge clk);
    dn_rvalid = 1; dn_err = 1; dn_rdata = 64'h0BAD_F00D_1234_5678; #1;
    chk("R9 rsp_valid", rsp_valid, 1);
    chk("R9 rsp_err", rsp_err, 1);
    chk("R9 rsp_rdata", rsp_rdata, 64'h0BAD_F00D_1234_5678);
    dn_err = 0; #1;
    chk("R9 rsp_err clear", rsp_err, 0);
    @(negedge clk); dn_rvalid = 0; dn_rdata = '0;
  endtask

  task automatic t_disable();
    set_cfg(0, 32'h9FE0_0000);
    drive(1, WB + 32'h20, 64'h1, 8'h01);
    chk("R6 disabled again", dn_valid, 0);
    finish_req();
    chk("R6 ack again", rsp_valid, 1);
    chk("R6 no err again", rsp_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pass();
    t_drop_write();
    t_err_read();
    t_enable();
    t_dn_rsp();
    t_disable();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); checks++; errors++; $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule